// File: doc/BRIEF.md
# Latched Output Event Flag Registers

This block watches a single routed output signal and presents it to software as a small bank of 32-bit registers on a plain synchronous register bus. Software can read the signal's present level at any time. It can also read a sticky event flag, which hardware sets on each low-to-high transition of the signal and which stays set until software clears it.

The flag is changed through two separate write-only ports. One port clears the flag when software writes a 1 to bit 0. The other port sets the flag when software writes a 1 to bit 0, which lets software raise the event itself. Both ports always read back as zero. When a hardware event and a software clear land in the same cycle, the event wins and the flag stays set, so an edge is never lost. Read data is returned combinationally in the cycle of the read strobe. The reset input is asynchronous and active low, and the block re-times its release to the clock.

Top module: `outev_flag_regs`

## Requirements
- R1: The registers sit at byte offsets 0x10 (live level), 0x18 (sticky flag), 0x1C (clear port) and 0x20 (force port). The decode compares the full address.
- R2: In every register, bits 31 to 1 read as zero, whatever data was written before.
- R3: Bit 0 at offset 0x10 returns the monitored signal's level in the same cycle: 1 for high and 0 for low.
- R4: A rising edge of the monitored signal sets the flag at the clock edge on which the signal is first sampled high. The flag then holds while the signal stays high, after it falls, and with no bus activity.
- R5: A write of 1 to bit 0 at offset 0x1C clears the flag at the next clock edge. A write of 0 leaves the flag unchanged.
- R6: A read at offset 0x1C always returns zero.
- R7: A write of 1 to bit 0 at offset 0x20 sets the flag at the next clock edge. A write of 0 leaves the flag unchanged. A read at offset 0x20 always returns zero.
- R8: When a rising edge and a clear write occur in the same cycle, the flag ends up set.
- R9: Reset forces the flag and the stored previous level to 0. The internal reset is released two clock edges after the reset input goes high.
- R10: A write to any offset not listed in R1 changes nothing. A read from such an offset returns zero.
- R11: While the read strobe is low, the read data bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_i | input | 1 | Monitored output signal, synchronous to clk |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of bus_ren |

## Verification
The assertions assume that the monitored signal is already synchronous to the clock and is held low while reset is asserted. If it were high when reset releases, it would register as a rising edge. The assertions also assume that the read strobe and the write strobe are never raised together. The bench meets these assumptions by changing the signal and the strobes only on the falling clock edge. It keeps the signal low through every reset, and it always separates a write cycle from the read cycle that follows it.

// File: rtl/outev_pkg.sv
package outev_pkg;

  // Byte offsets of the register bank
  localparam int unsigned OFF_LEVEL = 32'h10;
  localparam int unsigned OFF_FLAG  = 32'h18;
  localparam int unsigned OFF_CLEAR = 32'h1C;
  localparam int unsigned OFF_FORCE = 32'h20;

  // Register selected by the current address
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_FLAG,
    SEL_CLEAR,
    SEL_FORCE
  } reg_sel_e;

endpackage

// File: rtl/outev_rst_sync.sv
module outev_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/outev_edge_det.sv
module outev_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
    rise_o = sig_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  // A detected edge must leave the stored level high one cycle later
  AST_RISE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> prev_q) else $error("AST_RISE_STORED"); // R4

endmodule

// File: rtl/outev_flag_cell.sv
module outev_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;
  logic any_set;

  always_comb begin
    any_set = hw_set_i | sw_set_i;
    flag_en = any_set | sw_clr_i;
    // any set source takes priority over a clear
    flag_d  = any_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_HW_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set_i && sw_clr_i) |=> flag_o) else $error("AST_HW_BEATS_CLR"); // R8
  AST_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set_i |=> flag_o) else $error("AST_HW_SETS"); // R4
  AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_i |=> flag_o) else $error("AST_FORCE_SETS"); // R7
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && !hw_set_i && !sw_set_i) |=> !flag_o) else $error("AST_CLR_ONLY"); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_clr_i && !hw_set_i && !sw_set_i) |=> $stable(flag_o)) else $error("AST_FLAG_HOLDS"); // R4

endmodule

// File: rtl/outev_reg_if.sv
module outev_reg_if #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ren,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              level_i,
  input  logic              flag_i,
  output logic              clr_stb_o,
  output logic              frc_stb_o
);

  import outev_pkg::*;

  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFF_LEVEL);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFF_FLAG);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(OFF_FORCE);

  reg_sel_e    sel;
  logic        rd_bit;

  always_comb begin
    unique case (bus_addr)
      A_LEVEL: sel = SEL_LEVEL;
      A_FLAG:  sel = SEL_FLAG;
      A_CLEAR: sel = SEL_CLEAR;
      A_FORCE: sel = SEL_FORCE;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    clr_stb_o = bus_wen && (sel == SEL_CLEAR) && bus_wdata[0];
    frc_stb_o = bus_wen && (sel == SEL_FORCE) && bus_wdata[0];
  end

  always_comb begin
    case (sel)
      SEL_LEVEL: rd_bit = level_i;
      SEL_FLAG:  rd_bit = flag_i;
      default:   rd_bit = 1'b0;
    endcase
    bus_rdata = {{(DATA_W-1){1'b0}}, (bus_ren & rd_bit)};
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:1] == '0) else $error("AST_RSVD_ZERO"); // R2
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_stb_o, frc_stb_o})) else $error("AST_STB_EXCL"); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |-> (bus_rdata == '0)) else $error("AST_IDLE_ZERO"); // R11
  AST_PORT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CLEAR || sel == SEL_FORCE) |-> (bus_rdata == '0)) else $error("AST_PORT_RD_ZERO"); // R6

endmodule

// File: rtl/outev_flag_regs.sv
module outev_flag_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ren,
  output logic [DATA_W-1:0] bus_rdata
);

  logic rst_int_n;
  logic rise;
  logic clr_stb;
  logic frc_stb;
  logic flag;

  outev_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  outev_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sig_i  (mon_i),
    .rise_o (rise)
  );

  outev_flag_cell u_flag (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hw_set_i (rise),
    .sw_set_i (frc_stb),
    .sw_clr_i (clr_stb),
    .flag_o   (flag)
  );

  outev_reg_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .level_i   (mon_i),
    .flag_i    (flag),
    .clr_stb_o (clr_stb),
    .frc_stb_o (frc_stb)
  );

endmodule

// File: tb/outev_flag_regs_tb.sv
module outev_flag_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_i = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  outev_flag_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_i     (mon_i),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata)
  );

  // Vector: [19] level, [18] write, [17:10] write addr, [9] write bit0,
  //         [8:1] read addr, [0] expected read bit0
  localparam int NV = 15;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h18, 1'b0}, // R9 flag clear after reset
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h10, 1'b1}, // R3 live level high
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h18, 1'b1}, // R4 edge latched
    {1'b1, 1'b1, 8'h1C, 1'b1, 8'h18, 1'b0}, // R5 clear, steady high no relatch
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h10, 1'b0}, // R3 live level low
    {1'b0, 1'b1, 8'h20, 1'b0, 8'h18, 1'b0}, // R7 force with 0 ignored
    {1'b0, 1'b1, 8'h20, 1'b1, 8'h18, 1'b1}, // R7 force with 1 sets
    {1'b0, 1'b1, 8'h1C, 1'b0, 8'h18, 1'b1}, // R5 clear with 0 ignored
    {1'b0, 1'b1, 8'h14, 1'b1, 8'h18, 1'b1}, // R10 unlisted write ignored
    {1'b0, 1'b1, 8'h1C, 1'b1, 8'h18, 1'b0}, // R5 clear with 1
    {1'b0, 1'b1, 8'h1D, 1'b1, 8'h18, 1'b0}, // R10 near-miss address ignored
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h1C, 1'b0}, // R6 clear port reads 0
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h14, 1'b0}, // R10 unlisted read 0
    {1'b1, 1'b1, 8'h1C, 1'b1, 8'h18, 1'b1}, // R8 edge beats clear
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h20, 1'b0}  // R7 force port reads 0
  };
  localparam int VREQ [NV] = '{9, 3, 4, 5, 3, 7, 7, 5, 10, 5, 10, 6, 10, 8, 7};

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Write on one falling edge, hold through the rising edge
  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_ren = 1'b0; bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    bus_wen = 1'b0; bus_ren = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mon_i = 1'b0; bus_wen = 1'b0; bus_ren = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    do_reset();

    // Table walk: stimulus cycle, then a read cycle
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_ren  = 1'b0;
      mon_i    = VEC[i][19];
      bus_wen  = VEC[i][18];
      bus_addr = VEC[i][17:10];
      bus_wdata = {31'b0, VEC[i][9]};
      @(negedge clk);
      do_read(VEC[i][8:1], rd);
      check(VREQ[i], rd, {31'b0, VEC[i][0]});
    end

    // R11 idle bus reads zero while flag and level are high
    @(negedge clk);
    bus_ren = 1'b0; bus_addr = 8'h18;
    #1 check(11, bus_rdata, 32'h0);

    // R2 reserved bits stay zero after all-ones writes
    do_write(8'h1C, 32'hFFFF_FFFF);
    do_write(8'h20, 32'hFFFF_FFFF);
    do_read(8'h18, rd); check(2, rd, 32'h1);
    do_read(8'h10, rd); check(2, rd, 32'h1);
    do_read(8'h1C, rd); check(2, rd, 32'h0);
    do_read(8'h20, rd); check(2, rd, 32'h0);

    // R4 flag holds after level falls
    @(negedge clk); bus_ren = 1'b0; mon_i = 1'b0;
    repeat (3) @(negedge clk);
    do_read(8'h18, rd); check(4, rd, 32'h1);

    // R9 reset clears a set flag
    do_reset();
    do_read(8'h18, rd); check(9, rd, 32'h0);

    // R9 internal reset held for two edges after release
    @(negedge clk); bus_ren = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_i = 1'b1;
    @(negedge clk);  // one edge after release: still in reset
    do_read(8'h18, rd); check(9, rd, 32'h0);
    @(negedge clk);  // second edge releases, edge not yet latched
    do_read(8'h18, rd); check(9, rd, 32'h0);
    @(negedge clk);  // first active edge latches the high level
    do_read(8'h18, rd); check(4, rd, 32'h1);

    // R1 decode: force at 0x20 only, clear at 0x1C only
    do_write(8'h1C, 32'h1);
    do_read(8'h18, rd); check(1, rd, 32'h0);
    do_write(8'h21, 32'h1);
    do_read(8'h18, rd); check(1, rd, 32'h0);
    do_write(8'h20, 32'h1);
    do_read(8'h18, rd); check(1, rd, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule